// File: doc/BRIEF.md
# Weighted Consumer Queue Load Tracker

This block keeps a running load figure for each consumer queue of a load-balancing event scheduler. Each event handed to a queue carries a small weight. The weight is added to that queue's load counter and also recorded, in order, in a per-queue history FIFO. When the consumer reports a completion on that queue, the oldest recorded weight is taken from the FIFO and subtracted from the counter. A completion therefore returns exactly the weight that its own schedule added.

For each queue the block compares the load with a programmable capacity and gives the arbiter an eligibility bit. When weighting is switched off for a queue, that queue is always eligible, and its load is still tracked. A completion with no recorded work, or a schedule to a queue whose history is full, is dropped. Either one raises a sticky error bit.

Top module: `wq_load_tracker`

## Requirements
- R1: After reset every load reads 0, every eligibility bit is 1 and the error bit is 0.
- R2: A schedule adds the weight given by its 2-bit code to the load of the chosen queue, and the new load is visible one clock later. The code mapping is 00 = 0, 01 = 2, 10 = 4 and 11 = 8.
- R3: A completion subtracts the weight of the oldest schedule still outstanding on that queue, so weights come back in schedule order.
- R4: When a schedule and a completion hit the same queue in one cycle, the load changes by the new weight minus the returned weight in a single step.
- R5: A queue with weighting enabled is eligible exactly while its load is below its capacity. Capacity ranges from 0 to 256.
- R6: A queue with weighting disabled is eligible whatever its load, and its load is still tracked.
- R7: A completion on a queue with no outstanding schedules sets the error bit and leaves that queue's load unchanged.
- R8: A schedule to a queue that already holds HIST_DEPTH outstanding entries is not recorded, does not change the load, and sets the error bit.
- R9: Once set, the error bit stays set until reset.
- R10: Operations on one queue never change the load of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_vld | input | 1 | An event is scheduled this cycle |
| sched_q | input | $clog2(NUM_Q) | Queue receiving the event |
| sched_wcode | input | 2 | Weight code of the event |
| cmpl_vld | input | 1 | A completion arrives this cycle |
| cmpl_q | input | $clog2(NUM_Q) | Queue the completion belongs to |
| cap_i | input | NUM_Q*CAP_W | Capacity per queue, queue i at bits [i*CAP_W +: CAP_W] |
| wt_en_i | input | NUM_Q | Weighting enable per queue |
| eligible_o | output | NUM_Q | Queue may take more traffic |
| load_o | output | NUM_Q*LOAD_W | Load per queue, queue i at bits [i*LOAD_W +: LOAD_W] |
| err_o | output | 1 | Sticky error: underflowed or overflowed history |

## Verification
The assertions assume that the queue indices are below NUM_Q and that capacities are held steady while a check depends on them. They also rely on the internal guard keeping every push and pop that reaches a FIFO legal. The bench applies only in-range queue indices and sets capacities and enables once, before the first event. It produces empty-FIFO completions and full-FIFO schedules on purpose, so that the guard and the sticky error path are exercised without breaking those assumptions.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef logic [1:0] wcode_t;

  function automatic logic [3:0] wt_value(wcode_t c);
    return (c == 2'b00) ? 4'd0 : (4'd1 << c);
  endfunction
endpackage

// File: rtl/wq_hist_fifo.sv
module wq_hist_fifo #(
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  wq_pkg::wcode_t push_code,
  input  logic          pop,
  output wq_pkg::wcode_t head_code,
  output logic          empty,
  output logic          full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wq_pkg::wcode_t    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty     = (cnt == '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign head_code = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: the guard upstream never pushes into a full list
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R7: the guard upstream never pops an empty list
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wq_load_ctr.sv
module wq_load_ctr #(
  parameter int LOAD_W = 12,
  parameter int CAP_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_ok,
  input  wq_pkg::wcode_t    push_code,
  input  logic              pop_ok,
  input  wq_pkg::wcode_t    pop_code,
  input  logic [CAP_W-1:0]  cap,
  input  logic              wt_en,
  output logic [LOAD_W-1:0] load_q,
  output logic              eligible
);
  logic [LOAD_W-1:0] add_w, sub_w, cap_ext;

  function automatic logic [LOAD_W-1:0] next_load(logic [LOAD_W-1:0] cur,
                                                  logic [LOAD_W-1:0] add,
                                                  logic [LOAD_W-1:0] sub);
    return cur + add - sub;
  endfunction

  assign add_w   = push_ok ? LOAD_W'(wq_pkg::wt_value(push_code)) : '0;
  assign sub_w   = pop_ok  ? LOAD_W'(wq_pkg::wt_value(pop_code))  : '0;
  assign cap_ext = LOAD_W'(cap);
  assign eligible = !wt_en || (load_q < cap_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= '0;
    else        load_q <= next_load(load_q, add_w, sub_w);
  end

  // R3: a returned weight is always covered by the load it was added to
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> load_q >= LOAD_W'(wq_pkg::wt_value(pop_code)));
  // R10: without an operation on this queue its load holds
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ok && !pop_ok) |=> $stable(load_q));
endmodule

// File: rtl/wq_load_tracker.sv
module wq_load_tracker #(
  parameter int NUM_Q      = 4,
  parameter int HIST_DEPTH = 256,
  parameter int CAP_W      = 9,
  parameter int LOAD_W     = $clog2(HIST_DEPTH * 8 + 1),
  parameter int QW         = $clog2(NUM_Q)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sched_vld,
  input  logic [QW-1:0]           sched_q,
  input  logic [1:0]              sched_wcode,
  input  logic                    cmpl_vld,
  input  logic [QW-1:0]           cmpl_q,
  input  logic [NUM_Q*CAP_W-1:0]  cap_i,
  input  logic [NUM_Q-1:0]        wt_en_i,
  output logic [NUM_Q-1:0]        eligible_o,
  output logic [NUM_Q*LOAD_W-1:0] load_o,
  output logic                    err_o
);
  logic [NUM_Q-1:0] push_req, pop_req, push_ok, pop_ok;
  logic [NUM_Q-1:0] drop_push, drop_pop, fifo_full, fifo_empty;
  logic             err_q;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    wq_pkg::wcode_t head;

    assign push_req[i]  = sched_vld && (sched_q == QW'(i));
    assign pop_req[i]   = cmpl_vld  && (cmpl_q  == QW'(i));
    assign push_ok[i]   = push_req[i] && !fifo_full[i];
    assign pop_ok[i]    = pop_req[i]  && !fifo_empty[i];
    assign drop_push[i] = push_req[i] && fifo_full[i];
    assign drop_pop[i]  = pop_req[i]  && fifo_empty[i];

    wq_hist_fifo #(.DEPTH(HIST_DEPTH)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_ok[i]),
      .push_code (sched_wcode),
      .pop       (pop_ok[i]),
      .head_code (head),
      .empty     (fifo_empty[i]),
      .full      (fifo_full[i])
    );

    wq_load_ctr #(.LOAD_W(LOAD_W), .CAP_W(CAP_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_ok   (push_ok[i]),
      .push_code (sched_wcode),
      .pop_ok    (pop_ok[i]),
      .pop_code  (head),
      .cap       (cap_i[i*CAP_W +: CAP_W]),
      .wt_en     (wt_en_i[i]),
      .load_q    (load_o[i*LOAD_W +: LOAD_W]),
      .eligible  (eligible_o[i])
    );

    // R7: an empty-list completion is flagged on the next clock
    p_drop_pop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_pop[i] |=> err_o);
    // R8: a full-list schedule is flagged on the next clock
    p_drop_push_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drop_push[i] |=> err_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if ((|drop_push) || (|drop_pop)) err_q <= 1'b1;
  end
  assign err_o = err_q;

  // R9: the error bit never clears on its own
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R10: at most one queue is pushed and one popped per cycle
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_ok) && $onehot0(pop_ok));
endmodule

// File: tb/test_wq_load_tracker.sv
`timescale 1ns/1ps
module test_wq_load_tracker;
  localparam int NQ = 4, HD = 256, CW = 9, LW = 12, QW = 2;

  logic clk = 0, rst_n = 0;
  logic sched_vld = 0, cmpl_vld = 0;
  logic [QW-1:0] sched_q = '0, cmpl_q = '0;
  logic [1:0] sched_wcode = '0;
  logic [NQ*CW-1:0] cap_i;
  logic [NQ-1:0] wt_en_i;
  logic [NQ-1:0] eligible_o;
  logic [NQ*LW-1:0] load_o;
  logic err_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  wq_load_tracker #(.NUM_Q(NQ), .HIST_DEPTH(HD), .CAP_W(CW)) i_wq_load_tracker (
    .clk(clk), .rst_n(rst_n), .sched_vld(sched_vld), .sched_q(sched_q),
    .sched_wcode(sched_wcode), .cmpl_vld(cmpl_vld), .cmpl_q(cmpl_q),
    .cap_i(cap_i), .wt_en_i(wt_en_i), .eligible_o(eligible_o),
    .load_o(load_o), .err_o(err_o));

  // entry: {sched_vld, sched_q, code, cmpl_vld, cmpl_q, watched q, expected load}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,2'd0,2'b01,1'b0,2'd0,2'd0,12'd2},   // R2 code 01 -> 2
    {1'b1,2'd0,2'b11,1'b0,2'd0,2'd0,12'd10},  // R2 code 11 -> 8
    {1'b1,2'd1,2'b10,1'b0,2'd0,2'd1,12'd4},   // R2 code 10 -> 4
    {1'b0,2'd0,2'b00,1'b1,2'd0,2'd0,12'd8},   // R3 oldest weight 2 returns
    {1'b1,2'd0,2'b00,1'b1,2'd0,2'd0,12'd0},   // R4 +0 -8
    {1'b1,2'd2,2'b11,1'b0,2'd0,2'd2,12'd8},   // R2
    {1'b1,2'd1,2'b11,1'b1,2'd1,2'd1,12'd8},   // R4 +8 -4
    {1'b1,2'd3,2'b10,1'b0,2'd0,2'd3,12'd4},   // R2
    {1'b1,2'd2,2'b01,1'b1,2'd0,2'd2,12'd10},  // R10 two queues at once
    {1'b0,2'd0,2'b00,1'b1,2'd2,2'd2,12'd2},   // R3
    {1'b0,2'd0,2'b00,1'b1,2'd1,2'd1,12'd0},   // R3
    {1'b1,2'd0,2'b10,1'b0,2'd0,2'd0,12'd4},   // R2
    {1'b0,2'd0,2'b00,1'b1,2'd0,2'd0,12'd0}    // R3
  };

  function automatic int ld(int q);
    return int'(load_o[q*LW +: LW]);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(logic sv, logic [1:0] sq, logic [1:0] wc, logic cv, logic [1:0] cq);
    @(negedge clk);
    sched_vld = sv; sched_q = sq; sched_wcode = wc; cmpl_vld = cv; cmpl_q = cq;
    @(negedge clk);
    sched_vld = 0; cmpl_vld = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // q0 cap 10, q1 cap 8, q2 weighting off, q3 cap 256
    cap_i   = {9'd256, 9'd0, 9'd8, 9'd10};
    wt_en_i = 4'b1011;
    do_reset();
    for (int q = 0; q < NQ; q++) check("R1 load", ld(q), 0);
    check("R1 eligible", int'(eligible_o), 15);
    check("R1 err", int'(err_o), 0);

    for (int v = 0; v < NV; v++) begin
      op(VEC[v][21], VEC[v][20:19], VEC[v][18:17], VEC[v][16], VEC[v][15:14]);
      check("R2/R3/R4 load", ld(int'(VEC[v][13:12])), int'(VEC[v][11:0]));
      check("R7/R8 no err", int'(err_o), 0);
    end
    // R10: q3 untouched by later traffic on other queues
    check("R10 q3 load", ld(3), 4);

    // R5 capacity on q1 (cap 8)
    op(1, 2'd1, 2'b10, 0, 2'd0);
    check("R5 below cap", int'(eligible_o[1]), 1);
    op(1, 2'd1, 2'b10, 0, 2'd0);
    check("R5 at cap", int'(eligible_o[1]), 0);
    op(0, 2'd0, 2'b00, 1, 2'd1);
    check("R5 back below", int'(eligible_o[1]), 1);
    op(0, 2'd0, 2'b00, 1, 2'd1);
    check("R5 drained", ld(1), 0);

    // R6 q2 weighting off, load 2 -> 18 against cap 0
    op(1, 2'd2, 2'b11, 0, 2'd0);
    op(1, 2'd2, 2'b11, 0, 2'd0);
    check("R6 load tracked", ld(2), 18);
    check("R6 still eligible", int'(eligible_o[2]), 1);
    check("R10 q3 load", ld(3), 4);

    // R7 completion on empty q1
    op(0, 2'd0, 2'b00, 1, 2'd1);
    check("R7 err", int'(err_o), 1);
    check("R7 load kept", ld(1), 0);
    // R9 sticky through legal traffic
    op(1, 2'd1, 2'b01, 0, 2'd0);
    op(0, 2'd0, 2'b00, 1, 2'd1);
    check("R9 err held", int'(err_o), 1);
    check("R9 load", ld(1), 0);

    do_reset();
    check("R1 err cleared", int'(err_o), 0);
    check("R1 load q2", ld(2), 0);

    // R8 fill q3 with weight-0 entries
    for (int k = 0; k < HD; k++) op(1, 2'd3, 2'b00, 0, 2'd0);
    check("R8 full no err", int'(err_o), 0);
    op(1, 2'd3, 2'b11, 0, 2'd0);
    check("R8 err", int'(err_o), 1);
    check("R8 load kept", ld(3), 0);
    op(0, 2'd0, 2'b00, 1, 2'd3);
    check("R8 not recorded", ld(3), 0);
    check("R5 q3 eligible", int'(eligible_o[3]), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule